// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an already decoded addressing mode and the operand bytes of an 8-bit processor instruction into the 16-bit address the instruction will use. It receives the one or two operand bytes, the two index registers and the program counter value that follows the operand. For the three pointer-based modes it reads the two pointer bytes from memory itself, through a single-port synchronous read port with one cycle of read latency.

A one-cycle `start` pulse launches a calculation. Modes that need no memory access finish on the next clock. Pointer modes issue two back-to-back byte reads and then finish. The result and its valid flag stay in place until the next calculation completes. The block reproduces two quirks of this processor family. Zero-page arithmetic wraps inside page zero. In absolute indirect mode, the pointer increment does not carry into the pointer's high byte.

Top module: `eff_addr_unit`

## Requirements
- R1: During and after reset, with no start, `done`, `memRdEn`, `addrValid` are 0 and `effAddr` is 0x0000.
- R2: `mode` codes: 0 no address, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 pre-indexed indirect (X), 8 post-indexed indirect (Y), 9 absolute indirect, 10 relative. Codes 11 to 15 behave like 0. For zero page the result is {0x00, opLo}. For absolute it is {opHi, opLo}. Both finish with `done` high in the cycle right after the start cycle.
- R3: Zero page + X and zero page + Y give {0x00, (opLo + index) mod 256}, so the high byte is always 0x00.
- R4: Absolute + X and absolute + Y give ({opHi, opLo} + index) mod 65536, with carry into the high byte.
- R5: Pre-indexed indirect reads the low pointer byte at {0x00, (opLo + X) mod 256} and the high byte at {0x00, (opLo + X + 1) mod 256}. The result is {high, low}.
- R6: Post-indexed indirect reads the pointer at {0x00, opLo} and {0x00, (opLo + 1) mod 256}. The result is ({high, low} + Y) mod 65536.
- R7: Absolute indirect reads the low byte at {opHi, opLo} and the high byte at {opHi, (opLo + 1) mod 256}. When opLo is 0xFF the second read therefore stays at the start of the same page.
- R8: Relative mode gives (pcNext + opLo taken as a signed two's-complement byte) mod 65536.
- R9: Modes that produce no address complete like direct modes, with `addrValid` = 0 and `effAddr` = 0x0000. Every other mode completes with `addrValid` = 1.
- R10: In pointer modes `memRdEn` is high for exactly the first and second cycles after the start cycle, first with the low-byte address and then with the high-byte address. It is low in the third cycle. `done` is high in the fourth cycle.
- R11: A `start` that arrives while a pointer calculation is in progress is ignored, and the running calculation completes with its own result.
- R12: `effAddr` and `addrValid` change only in a cycle where `done` is high, and otherwise hold the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compute an address |
| mode | input | 4 | Addressing mode code (see R2) |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte (absolute forms) |
| idxX | input | 8 | X index register |
| idxY | input | 8 | Y index register |
| pcNext | input | 16 | Program counter after the operand byte |
| memRdEn | output | 1 | Pointer byte read request |
| memAddr | output | 16 | Pointer byte read address |
| memRdData | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion strobe |
| effAddr | output | 16 | Effective address result |
| addrValid | output | 1 | Result is a real memory address |

## Verification
Direct and relative modes must show their result and `done` in the first cycle after the start cycle. Pointer modes must show read requests in the first and second cycles, an idle third cycle, and the result in the fourth. The bench drives `start` on a falling edge and recomputes the expected address, read addresses and memory contents for each job from integers and a formula-based memory. It then compares every output at each following falling edge against that per-cycle schedule. This exposes a read or a result that arrives one cycle early or late, and any drift of the held result between jobs.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    AM_NONE   = 4'd0,
    AM_ZP     = 4'd1,
    AM_ZPX    = 4'd2,
    AM_ZPY    = 4'd3,
    AM_ABS    = 4'd4,
    AM_ABSX   = 4'd5,
    AM_ABSY   = 4'd6,
    AM_INDX   = 4'd7,
    AM_INDY   = 4'd8,
    AM_ABSIND = 4'd9,
    AM_REL    = 4'd10
  } amode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // start accepted this cycle
    logic issueLo;  // low pointer byte read on the port
    logic issueHi;  // high pointer byte read on the port
    logic takeLo;   // low pointer byte present on read data
    logic finish;   // high pointer byte present on read data
  } eagStrobe_t;

  function automatic logic isIndirect(input logic [3:0] m);
    return (m == AM_INDX) || (m == AM_INDY) || (m == AM_ABSIND);
  endfunction

  function automatic logic hasAddr(input logic [3:0] m);
    return (m >= AM_ZP) && (m <= AM_REL);
  endfunction

  function automatic logic isZeroPage(input logic [3:0] m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output eagStrobe_t strobe,
  output logic       memRdEn,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RDLO, ST_RDHI, ST_FIN} state_e;

  state_e state, stateNext;

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == ST_IDLE) && start;
    strobe.issueLo = (state == ST_RDLO);
    strobe.issueHi = (state == ST_RDHI);
    strobe.takeLo  = (state == ST_RDHI);
    strobe.finish  = (state == ST_FIN);
  end

  assign memRdEn = strobe.issueLo | strobe.issueHi;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start && isIndirect(mode)) stateNext = ST_RDLO;
      ST_RDLO: stateNext = ST_RDHI;
      ST_RDHI: stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (strobe.capture && !isIndirect(mode)) || strobe.finish;
    end
  end

  // R10: the two pointer reads are issued back to back
  a_r10_read_pair: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueLo |=> (memRdEn && strobe.issueHi));

  // R10: completion never follows a read request directly
  a_r10_no_early_done: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !done);

  // R11: a start during a pointer job does not restart it
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueLo && start) |=> (state == ST_RDHI));

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eagStrobe_t        strobe,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] opLo,
  input  logic [DATA_W-1:0] opHi,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcNext,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [3:0]        modeQ;
  logic [DATA_W-1:0] yQ;
  logic [DATA_W-1:0] ptrLoQ;
  logic [ADDR_W-1:0] ptrBaseQ;

  logic [DATA_W-1:0] zpX, zpY;
  logic [ADDR_W-1:0] absBase, directAddr, ptrBase, ptrFull, relOff;

  assign zpX     = opLo + idxX;
  assign zpY     = opLo + idxY;
  assign absBase = {opHi, opLo};
  assign relOff  = {{HI_W{opLo[DATA_W-1]}}, opLo};

  // addresses resolved at the start edge
  always_comb begin
    unique case (mode)
      AM_ZP:   directAddr = {{HI_W{1'b0}}, opLo};
      AM_ZPX:  directAddr = {{HI_W{1'b0}}, zpX};
      AM_ZPY:  directAddr = {{HI_W{1'b0}}, zpY};
      AM_ABS:  directAddr = absBase;
      AM_ABSX: directAddr = absBase + {{HI_W{1'b0}}, idxX};
      AM_ABSY: directAddr = absBase + {{HI_W{1'b0}}, idxY};
      AM_REL:  directAddr = pcNext + relOff;
      default: directAddr = '0;
    endcase
  end

  // where the low pointer byte lives
  always_comb begin
    unique case (mode)
      AM_INDX: ptrBase = {{HI_W{1'b0}}, zpX};
      AM_INDY: ptrBase = {{HI_W{1'b0}}, opLo};
      default: ptrBase = absBase;
    endcase
  end

  // high byte read: low byte incremented without carry into the page
  always_comb begin
    if (strobe.issueHi)
      memAddr = {ptrBaseQ[ADDR_W-1:DATA_W], ptrBaseQ[DATA_W-1:0] + 1'b1};
    else
      memAddr = ptrBaseQ;
  end

  assign ptrFull = {memRdData, ptrLoQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= AM_NONE;
      yQ        <= '0;
      ptrLoQ    <= '0;
      ptrBaseQ  <= '0;
      effAddr   <= '0;
      addrValid <= 1'b0;
    end else begin
      if (strobe.capture) begin
        modeQ    <= mode;
        yQ       <= idxY;
        ptrBaseQ <= ptrBase;
        if (!isIndirect(mode)) begin
          effAddr   <= directAddr;
          addrValid <= hasAddr(mode);
        end
      end
      if (strobe.takeLo) ptrLoQ <= memRdData;
      if (strobe.finish) begin
        effAddr   <= (modeQ == AM_INDY) ? ptrFull + {{HI_W{1'b0}}, yQ} : ptrFull;
        addrValid <= 1'b1;
      end
    end
  end

  // R3: zero-page results never leave page zero
  a_r3_zp_page: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && isZeroPage(mode)) |=> (effAddr[ADDR_W-1:DATA_W] == '0));

  // R7: the second pointer read stays in the page of the first
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueHi |-> (memAddr[ADDR_W-1:DATA_W] == $past(memAddr[ADDR_W-1:DATA_W])));

  // R9: address-less modes clear the valid flag
  a_r9_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !hasAddr(mode)) |=> !addrValid);

  // R12: the result holds outside completion
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture || strobe.finish) |=> ($stable(effAddr) && $stable(addrValid)));

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] opLo,
  input  logic [DATA_W-1:0] opHi,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcNext,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid
);

  eagStrobe_t strobe;

  eag_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (mode),
    .strobe  (strobe),
    .memRdEn (memRdEn),
    .done    (done)
  );

  eag_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (mode),
    .opLo      (opLo),
    .opHi      (opHi),
    .idxX      (idxX),
    .idxY      (idxY),
    .pcNext    (pcNext),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .effAddr   (effAddr),
    .addrValid (addrValid)
  );

endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, idxX = '0, idxY = '0;
  logic [15:0] pcNext = '0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData = '0;
  logic        done;
  logic [15:0] effAddr;
  logic        addrValid;

  int nTests = 0;
  int nFail  = 0;
  int lastEa = 0;
  int lastValid = 0;

  always #2 clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .opLo(opLo), .opHi(opHi),
    .idxX(idxX), .idxY(idxY), .pcNext(pcNext), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .done(done), .effAddr(effAddr), .addrValid(addrValid)
  );

  function automatic int memFn(input int a);
    return (((a % 256) * 7) + (a / 256) * 3 + 17) % 256;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= 8'(memFn(int'(memAddr)));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input int md, input int lo, input int hi, input int xv,
                       input int yv, input int pcv, input string tag, input bit pokeBusy);
    int ea, valid, loA, hiA, off, p;
    bit ind;
    ind = 0; loA = 0; hiA = 0; valid = 1;
    case (md)
      1: ea = lo;
      2: ea = (lo + xv) % 256;
      3: ea = (lo + yv) % 256;
      4: ea = hi * 256 + lo;
      5: ea = (hi * 256 + lo + xv) % 65536;
      6: ea = (hi * 256 + lo + yv) % 65536;
      7: begin ind = 1; p = (lo + xv) % 256; loA = p; hiA = (p + 1) % 256;
           ea = memFn(hiA) * 256 + memFn(loA); end
      8: begin ind = 1; loA = lo; hiA = (lo + 1) % 256;
           ea = (memFn(hiA) * 256 + memFn(loA) + yv) % 65536; end
      9: begin ind = 1; loA = hi * 256 + lo; hiA = hi * 256 + (lo + 1) % 256;
           ea = memFn(hiA) * 256 + memFn(loA); end
      10: begin off = (lo >= 128) ? lo - 256 : lo; ea = (pcv + off + 65536) % 65536; end
      default: begin ea = 0; valid = 0; end
    endcase
    @(negedge clk);
    start = 1'b1; mode = 4'(md); opLo = 8'(lo); opHi = 8'(hi);
    idxX = 8'(xv); idxY = 8'(yv); pcNext = 16'(pcv);
    @(posedge clk);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (ind) begin
        chk(memRdEn == (c <= 2), "R10 read enable", int'(memRdEn), int'(c <= 2));
        if (c == 1) chk(int'(memAddr) == loA, {tag, " low read addr"}, int'(memAddr), loA);
        if (c == 2) chk(int'(memAddr) == hiA, {tag, " high read addr"}, int'(memAddr), hiA);
        chk(done == (c == 4), "R10 done timing", int'(done), int'(c == 4));
        if (c == 2 && pokeBusy) begin
          start = 1'b1; mode = 4'd1; opLo = 8'h33;
        end
        if (c == 4) begin
          chk(int'(effAddr) == ea, tag, int'(effAddr), ea);
          chk(int'(addrValid) == valid, "R9 valid", int'(addrValid), valid);
          lastEa = ea; lastValid = valid;
        end else
          chk(int'(effAddr) == lastEa, "R12 hold", int'(effAddr), lastEa);
      end else begin
        chk(memRdEn == 1'b0, "R10 no read", int'(memRdEn), 0);
        chk(done == (c == 1), "R2 done timing", int'(done), int'(c == 1));
        if (c == 1) begin
          lastEa = ea; lastValid = valid;
          chk(int'(addrValid) == valid, "R9 valid", int'(addrValid), valid);
        end
        chk(int'(effAddr) == ea, (c == 1) ? tag : "R12 hold", int'(effAddr), ea);
      end
    end
    // idle: result must stay
    @(negedge clk);
    chk(int'(effAddr) == lastEa && int'(addrValid) == lastValid && !done,
        "R12 idle hold", int'(effAddr), lastEa);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !memRdEn && !addrValid && effAddr == 16'h0, "R1 reset",
            int'(effAddr), 0);
        rstN = 1'b1;
        @(negedge clk);
        chk(!done && !memRdEn && !addrValid && effAddr == 16'h0, "R1 after reset",
            int'(effAddr), 0);
        runOp(1, 'h42, 'h99, 0, 0, 0, "R2 zero page", 0);
        runOp(4, 'h34, 'h12, 0, 0, 0, "R2 absolute", 0);
        runOp(2, 'hF0, 'h55, 'h20, 0, 0, "R3 zp+X wrap", 0);
        runOp(3, 'hFF, 'h55, 0, 'h01, 0, "R3 zp+Y wrap", 0);
        runOp(2, 'h10, 0, 'h05, 0, 0, "R3 zp+X plain", 0);
        runOp(5, 'hF0, 'h12, 'h20, 0, 0, "R4 abs+X carry", 0);
        runOp(6, 'hF0, 'hFF, 0, 'h20, 0, "R4 abs+Y wrap", 0);
        runOp(7, 'hFE, 'h77, 'h01, 0, 0, "R5 pre-indexed wrap", 0);
        runOp(7, 'h20, 0, 'h04, 0, 0, "R5 pre-indexed", 0);
        runOp(8, 'hFF, 'h77, 0, 'hC0, 0, "R6 post-indexed wrap", 0);
        runOp(8, 'h40, 0, 0, 'hFF, 0, "R6 post-indexed", 0);
        runOp(9, 'hFF, 'h30, 0, 0, 0, "R7 indirect page defect", 0);
        runOp(9, 'h80, 'h30, 0, 0, 0, "R7 indirect plain", 0);
        runOp(10, 'h10, 0, 0, 0, 'h1234, "R8 relative fwd", 0);
        runOp(10, 'hF0, 0, 0, 0, 'h1234, "R8 relative back", 0);
        runOp(10, 'h80, 0, 0, 0, 'h0010, "R8 relative wrap", 0);
        runOp(0, 'h12, 'h34, 0, 0, 0, "R9 no address", 0);
        runOp(5, 'h01, 'h02, 'h03, 0, 0, "R4 abs+X", 0);
        runOp(12, 'h12, 'h34, 0, 0, 0, "R9 unused code", 0);
        runOp(9, 'h10, 'h44, 0, 0, 0, "R11 busy start ignored", 1);
        runOp(8, 'h05, 0, 0, 'h02, 0, "R11 busy start ignored", 1);
      end
      begin
        repeat (100000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule